// File: doc/BRIEF.md
# RTS Hold-Time Limiter

This block sits between the modem-control pins of one V.24 serial data port and the multiplexer that carries that port's traffic. It lets the attached terminal open the transmit path by raising RTS, but only for a bounded time. If RTS stays on past the hold limit, the block turns CTS off and drops the carrier indication it sends to the far end. It also parks the transmit data line at the idle mark level. A stuck remote unit on a shared polling line therefore cannot occupy the channel for good.

The lockout is latched. It clears only after RTS has been seen off for an unbroken quiet interval. If RTS returns at any point during that interval, the quiet timer starts again from zero. A single strap selects the behaviour. With the strap low, RTS passes straight through to CTS and the far-end carrier with no limit, which suits protection-relay links and bench testing with a data tester. RTS is synchronised into the clock domain before use. Both intervals are counted in clock cycles, derived from the clock frequency and a time in milliseconds (default 2000 ms each).

Top module: `rts_hold_limiter`

## Requirements
- R1: While reset is asserted, `cts_out` and `rdcd_out` are 0 and `txd_out` equals `txd_in`.
- R2: With the limiter enabled and no lockout active, `cts_out` and `rdcd_out` equal `rts_in` delayed by two clock edges through a two-flop synchroniser.
- R3: With the limiter enabled, once the synchronised RTS has been high for HOLD consecutive cycles, `cts_out` and `rdcd_out` go to 0 from the next cycle and stay 0 while the lockout lasts. HOLD = CLK_HZ*HOLD_MS/1000.
- R4: If the synchronised RTS falls before HOLD cycles have passed, the on-timer restarts, and the next RTS-on period is again granted a full HOLD cycles.
- R5: During a lockout `txd_out` is held at 1 (mark). At all other times it follows `txd_in` combinationally.
- R6: A lockout clears only after the synchronised RTS has been low for QUIET consecutive cycles, with QUIET = CLK_HZ*QUIET_MS/1000. Any high cycle in between restarts that count from zero. After it clears, RTS is again passed through as in R2.
- R7: With `limit_en` at 0, `cts_out` and `rdcd_out` follow the synchronised RTS with no time limit and `txd_out` follows `txd_in`. A pending lockout is discarded, and counting starts afresh once the strap returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| limit_en | input | 1 | 1 = enforce hold limit, 0 = plain pass-through |
| rts_in | input | 1 | Request-to-send from the terminal, asynchronous |
| txd_in | input | 1 | Raw transmit data from the terminal |
| cts_out | output | 1 | Clear-to-send towards the terminal |
| rdcd_out | output | 1 | Carrier indication to be signalled to the far end |
| txd_out | output | 1 | Transmit data after gating, mark while locked out |

## Verification
The main pattern is a sweep of every RTS on-width from one cycle to beyond the hold limit, crossed with every off-gap from one cycle to beyond the quiet interval. Short widths show that ordinary handshakes pass unaltered. Widths at exactly the limit and at the limit plus one show the boundary of the lockout. Gaps just under and just over the quiet length show whether release comes one cycle early or late. Directed patterns cover an RTS that drops one cycle short of the limit and then returns, a reassertion inside the quiet window, and the strap being dropped mid-lockout. These distinguish a timer that fails to restart from one that restarts correctly, and a stale lockout from one that is properly cleared.

// File: rtl/rts_limit_pkg.sv
package rts_limit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_LOCK = 2'd2
  } hold_state_e;

  // Interval length in clock cycles from a frequency and a time in ms.
  function automatic int unsigned ms_to_cycles(input int unsigned hz,
                                               input int unsigned ms);
    longint unsigned prod;
    prod = (longint'(hz) * longint'(ms)) / 64'd1000;
    return 32'(prod);
  endfunction

  // Counter width able to reach the larger of two limits.
  function automatic int unsigned count_bits(input int unsigned a,
                                             input int unsigned b);
    int unsigned top;
    top = (a > b) ? a : b;
    return (top < 2) ? 1 : $clog2(top + 1);
  endfunction

  // True when one more counted cycle reaches the limit.
  function automatic logic step_hits(input logic [31:0] cur,
                                     input logic [31:0] lim);
    return (cur + 32'd1) >= lim;
  endfunction

endpackage

// File: rtl/rts_sync.sv
module rts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];

  // R2
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain[STAGES-1] == $past(chain[STAGES-2]));

endmodule

// File: rtl/rts_interval_timer.sv
module rts_interval_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> (cnt != {CW{1'b1}}));

endmodule

// File: rtl/rts_lockout_fsm.sv
module rts_lockout_fsm
  import rts_limit_pkg::*;
#(
  parameter int unsigned HOLD  = 8,
  parameter int unsigned QUIET = 8,
  parameter int unsigned CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rts_s,
  input  logic [CW-1:0] cnt,
  output hold_state_e   state,
  output logic          tmr_clr,
  output logic          tmr_inc,
  output logic          locked,
  output logic          hold_expire,
  output logic          quiet_done
);

  hold_state_e state_nx;
  logic [31:0] cnt32;

  assign cnt32 = 32'(cnt);

  // Internal events, named for the checks below.
  always_comb begin
    hold_expire = 1'b0;
    if (en && rts_s) begin
      if (state == ST_IDLE)      hold_expire = (HOLD <= 1);
      else if (state == ST_OPEN) hold_expire = step_hits(cnt32, HOLD);
    end
  end

  assign quiet_done = en && (state == ST_LOCK) && !rts_s
                      && step_hits(cnt32, QUIET);

  always_comb begin
    state_nx = state;
    tmr_clr  = 1'b0;
    tmr_inc  = 1'b0;
    if (!en) begin
      state_nx = ST_IDLE;
      tmr_clr  = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rts_s && hold_expire) begin
            state_nx = ST_LOCK;
            tmr_clr  = 1'b1;
          end else if (rts_s) begin
            state_nx = ST_OPEN;
            tmr_inc  = 1'b1;
          end else begin
            tmr_clr  = 1'b1;
          end
        end
        ST_OPEN: begin
          if (!rts_s) begin
            state_nx = ST_IDLE;
            tmr_clr  = 1'b1;
          end else if (hold_expire) begin
            state_nx = ST_LOCK;
            tmr_clr  = 1'b1;
          end else begin
            tmr_inc  = 1'b1;
          end
        end
        ST_LOCK: begin
          if (rts_s) begin
            tmr_clr  = 1'b1;
          end else if (quiet_done) begin
            state_nx = ST_IDLE;
            tmr_clr  = 1'b1;
          end else begin
            tmr_inc  = 1'b1;
          end
        end
        default: begin
          state_nx = ST_IDLE;
          tmr_clr  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign locked = (state == ST_LOCK);

  // R3
  open_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rts_s && state == ST_OPEN && cnt == CW'(HOLD - 1))
      |=> (state == ST_LOCK));

  // R4
  drop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rts_s && state == ST_OPEN) |=> (state == ST_IDLE && cnt == '0));

  // R6
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rts_s && state == ST_LOCK) |=> (state == ST_LOCK && cnt == '0));

  // R7
  strap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == ST_IDLE && cnt == '0));

endmodule

// File: rtl/rts_hold_limiter.sv
module rts_hold_limiter
  import rts_limit_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned HOLD_MS     = 2000,
  parameter int unsigned QUIET_MS    = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic limit_en,
  input  logic rts_in,
  input  logic txd_in,
  output logic cts_out,
  output logic rdcd_out,
  output logic txd_out
);

  localparam int unsigned HOLD_CYC  = ms_to_cycles(CLK_HZ, HOLD_MS);
  localparam int unsigned QUIET_CYC = ms_to_cycles(CLK_HZ, QUIET_MS);
  localparam int unsigned CW        = count_bits(HOLD_CYC, QUIET_CYC);

  logic          rts_s;
  logic [CW-1:0] tmr_cnt;
  logic          tmr_clr;
  logic          tmr_inc;
  logic          locked;
  logic          hold_expire;
  logic          quiet_done;
  logic          blocked;
  hold_state_e   state;

  rts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rts_in),
    .q_sync  (rts_s)
  );

  rts_interval_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .inc   (tmr_inc),
    .cnt   (tmr_cnt)
  );

  rts_lockout_fsm #(
    .HOLD  (HOLD_CYC),
    .QUIET (QUIET_CYC),
    .CW    (CW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (limit_en),
    .rts_s       (rts_s),
    .cnt         (tmr_cnt),
    .state       (state),
    .tmr_clr     (tmr_clr),
    .tmr_inc     (tmr_inc),
    .locked      (locked),
    .hold_expire (hold_expire),
    .quiet_done  (quiet_done)
  );

  assign blocked  = limit_en && locked;
  assign cts_out  = rts_s && !blocked;
  assign rdcd_out = rts_s && !blocked;
  assign txd_out  = blocked ? 1'b1 : txd_in;

  // R5
  lock_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_en && $past(limit_en) && $fell(cts_out) && rts_s) |-> txd_out);

  // R3
  expire_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_en && hold_expire) |=> (limit_en -> !cts_out));

  // R6
  release_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_done |=> (state == ST_IDLE));

endmodule

// File: tb/test_rts_hold_limiter.sv
module test_rts_hold_limiter;

  localparam int unsigned T_HZ    = 4000;
  localparam int unsigned T_HOLDM = 2;
  localparam int unsigned T_QUIM  = 1;
  localparam int HOLD  = 8;   // 4000 Hz * 2 ms
  localparam int QUIET = 4;   // 4000 Hz * 1 ms

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic limit_en = 1'b1;
  logic rts_in = 1'b0;
  logic txd_in = 1'b0;
  logic cts_out, rdcd_out, txd_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cyc = 0;

  // reference model state
  logic m_h1 = 1'b0, m_h2 = 1'b0;
  logic m_s_prev = 1'b0, m_en_prev = 1'b1;
  bit   m_lock = 1'b0;
  int   m_run = 0, m_quiet = 0;
  string sect = "";

  always #10 clk = ~clk;

  rts_hold_limiter #(
    .CLK_HZ(T_HZ), .HOLD_MS(T_HOLDM), .QUIET_MS(T_QUIM), .SYNC_STAGES(2)
  ) i_rts_hold_limiter (
    .clk(clk), .rst_n(rst_n), .limit_en(limit_en), .rts_in(rts_in),
    .txd_in(txd_in), .cts_out(cts_out), .rdcd_out(rdcd_out),
    .txd_out(txd_out)
  );

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle=%0d actual=%b expected=%b",
               tag, what, cyc, act, exp);
    end
  endtask

  task automatic tick(input logic rv, input logic ev);
    logic s, e_cts, e_txd;
    string t_ctl, t_txd;
    @(negedge clk);
    // advance model by the edge that just passed
    if (!m_en_prev) begin
      m_lock = 0; m_run = 0; m_quiet = 0;
    end else if (!m_lock) begin
      if (m_s_prev) begin
        m_run = m_run + 1;
        if (m_run >= HOLD) begin m_lock = 1; m_run = 0; m_quiet = 0; end
      end else m_run = 0;
    end else begin
      if (m_s_prev) m_quiet = 0;
      else begin
        m_quiet = m_quiet + 1;
        if (m_quiet >= QUIET) begin m_lock = 0; m_quiet = 0; m_run = 0; end
      end
    end
    s = m_h2;
    e_cts = limit_en ? (s && !m_lock) : s;
    e_txd = (limit_en && m_lock) ? 1'b1 : txd_in;
    if (sect != "")          t_ctl = sect;
    else if (!limit_en)      t_ctl = "R7";
    else if (m_lock)         t_ctl = "R3";
    else                     t_ctl = "R2";
    t_txd = (limit_en && m_lock) ? "R5" : t_ctl;
    check(t_ctl, "cts_out", cts_out, e_cts);
    check(t_ctl, "rdcd_out", rdcd_out, e_cts);
    check(t_txd, "txd_out", txd_out, e_txd);
    // drive next cycle
    m_h2 = m_h1; m_h1 = rv;
    rts_in = rv; limit_en = ev;
    txd_in = cyc[0] ^ cyc[2];
    m_s_prev = s; m_en_prev = ev;
    cyc++;
  endtask

  task automatic hold_level(input logic rv, input logic ev, input int n);
    for (int k = 0; k < n; k++) tick(rv, ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, txd passes in both levels
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      txd_in = k[0];
      rts_in = 1'b1;
      #1;
      check("R1", "cts_out", cts_out, 1'b0);
      check("R1", "rdcd_out", rdcd_out, 1'b0);
      check("R1", "txd_out", txd_out, txd_in);
    end
    @(negedge clk);
    rts_in = 1'b0;
    rst_n = 1'b1;
    hold_level(1'b0, 1'b1, 4);

    // Sweep of on-widths against off-gaps (R2 R3 R5 R6 boundaries)
    for (int w = 1; w <= HOLD + 2; w++) begin
      for (int g = 1; g <= QUIET + 2; g++) begin
        hold_level(1'b1, 1'b1, w);
        hold_level(1'b0, 1'b1, g);
        hold_level(1'b1, 1'b1, 2);
        hold_level(1'b0, 1'b1, QUIET + 4);
      end
    end

    // R4: drop one cycle short of the limit, then come back
    sect = "R4";
    hold_level(1'b1, 1'b1, HOLD - 1);
    hold_level(1'b0, 1'b1, 1);
    hold_level(1'b1, 1'b1, HOLD - 1);
    hold_level(1'b0, 1'b1, QUIET + 4);

    // R6: reassert inside the quiet window restarts it
    sect = "R6";
    hold_level(1'b1, 1'b1, HOLD + 3);
    hold_level(1'b0, 1'b1, QUIET - 1);
    hold_level(1'b1, 1'b1, 1);
    hold_level(1'b0, 1'b1, QUIET - 1);
    hold_level(1'b1, 1'b1, 3);
    hold_level(1'b0, 1'b1, QUIET + 1);
    hold_level(1'b1, 1'b1, 4);
    hold_level(1'b0, 1'b1, QUIET + 4);

    // R7: strap low gives unlimited pass-through and clears lockout
    sect = "R7";
    hold_level(1'b1, 1'b0, 3 * HOLD);
    hold_level(1'b0, 1'b0, 3);
    hold_level(1'b1, 1'b1, HOLD + 3);
    hold_level(1'b1, 1'b0, 3);
    hold_level(1'b1, 1'b1, HOLD + 4);
    hold_level(1'b0, 1'b1, QUIET + 4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule